// File: doc/BRIEF.md
# Dot-Clock PLL Divider Search

This block turns a requested pixel period, given in picoseconds, into the three register codes that program a dot-clock PLL running from a 14,318,180 Hz reference. The codes are the feedback divider, the reference divider and a post-divide/loop-divide code. A controller drives the period and pulses `start`. The block then works through its steps one at a time.

First it converts the period to a target frequency with a restoring shift-subtract divider. It rejects targets outside the supported window. It doubles an accepted target into the VCO range and records one post-divide step for each doubling. It then walks every reference divider from 3 to 257 and keeps the pair with the smallest frequency error.

Large feedback values are allowed when the PLL divides its loop by four. In that case the feedback value is quantised to a multiple of four when the error is measured. At the end `done` pulses for one cycle. The codes stay on the outputs until the next successful request.

Top module: `dpll_param_search`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and `m_code`, `n_code` and `div_code` are all 0.
- R2: A `start` seen while idle raises `busy` on the next clock edge. Completion is marked by `done` high for exactly one cycle with `busy` already low in that cycle.
- R3: The target is F = 10^6·floor(10^6/p) + floor(10^6·(10^6 mod p)/p), where p is the period. If p = 0, F < 3,125,000 or F > 220,000,000, then `done` pulses with `err` = 1 and the three codes keep their previous values. `err` returns to 0 at the next accepted `start`.
- R4: While F < 100,000,000 it is doubled. `div_code[7:4]` holds the number of doublings, so the code gains 0x10 per doubling.
- R5: For each N from 3 to 257, M = floor(N·F/14,318,180) after doubling. The error is N·F − 14,318,180·M' with no wraparound. M' = M when 3 ≤ M ≤ 257, and M' = M with its two low bits cleared otherwise, provided M ≤ 1028. A candidate with M > 1028 is skipped.
- R6: A candidate replaces the best one only when its error is strictly smaller, so on a tie the smallest N is kept.
- R7: On success `n_code` = N − 2. If the best M > 257, then `m_code` = (M >> 2) − 2 and `div_code[2]` = 0 (loop divide by 4). Otherwise `m_code` = M − 2 and `div_code[2]` = 1 (loop divide by 1). `div_code[3]` and `div_code[1:0]` are 0.
- R8: A `start` pulse while `busy` is high is ignored. The running request finishes with its own period and gives one `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only while idle |
| period_ps | input | PW (24) | Requested pixel period in picoseconds |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request was rejected (valid from `done` on) |
| m_code | output | 8 | Feedback divider code |
| n_code | output | 8 | Reference divider code |
| div_code | output | 8 | Post-divide steps in [7:4], loop-divide select in [2] |

## Verification
The divider check expects its divisor to be nonzero. The engine never starts a division with a zero period, because it rejects that case first. The reference constant is nonzero by construction.

The bound on the chosen feedback value assumes that, after doubling, every accepted target sits between 100 MHz and 220 MHz. Under that assumption the first swept divider always yields an in-range candidate.

The stimulus holds `period_ps` steady for the whole of each request. It uses periods within 24 bits, including zero, both edges of the frequency window and values far outside it. Overlapping `start` pulses are sent only to probe the ignore rule.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
    localparam int FW = 48;   // frequency / product datapath width
    localparam int NW = 9;    // reference divider width (up to 257)
    localparam int MW = 16;   // feedback divider width

    localparam logic [FW-1:0] ONE_M     = 48'd1000000;
    localparam logic [FW-1:0] REF_HZ    = 48'd14318180;
    localparam logic [FW-1:0] F_MIN     = 48'd3125000;
    localparam logic [FW-1:0] F_MAX     = 48'd220000000;
    localparam logic [FW-1:0] F_VCO_LO  = 48'd100000000;

    localparam logic [NW-1:0] N_FIRST   = 9'd3;
    localparam logic [NW-1:0] N_LAST    = 9'd257;
    localparam logic [MW-1:0] M_FINE_LO = 16'd3;
    localparam logic [MW-1:0] M_FINE_HI = 16'd257;
    localparam logic [MW-1:0] M_CRS_HI  = 16'd1028;

    localparam logic [7:0] POST_STEP = 8'h10;
    localparam logic [7:0] LOOP_DIV1 = 8'h04;

    typedef enum logic [2:0] {
        S_IDLE, S_DIV_A, S_DIV_B, S_RANGE, S_DOUBLE, S_DIV_C, S_SWEEP, S_FIN
    } srch_state_e;
endpackage

// File: rtl/dpll_divider.sv
module dpll_divider #(
    parameter int DVW = 48,
    parameter int DSW = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [DVW-1:0] dividend,
    input  logic [DSW-1:0] divisor,
    output logic           valid,
    output logic [DVW-1:0] quot,
    output logic [DSW-1:0] rem
);
    localparam int CW = $clog2(DVW + 1);

    typedef struct packed {
        logic           run;
        logic           valid;
        logic [CW-1:0]  cnt;
        logic [DVW-1:0] num;
        logic [DSW-1:0] den;
        logic [DSW:0]   part;
    } div_t;

    div_t q, d;
    logic [DSW:0] trial;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        trial   = {q.part[DSW-1:0], q.num[DVW-1]};
        if (go && !q.run) begin
            d.run  = 1'b1;
            d.num  = dividend;
            d.den  = divisor;
            d.part = '0;
            d.cnt  = CW'(DVW);
        end else if (q.run) begin
            // restoring step: quotient bits shift into num from the right
            if (trial >= {1'b0, q.den}) begin
                d.part = trial - {1'b0, q.den};
                d.num  = {q.num[DVW-2:0], 1'b1};
            end else begin
                d.part = trial;
                d.num  = {q.num[DVW-2:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.run   = 1'b0;
                d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid = q.valid;
    assign quot  = q.num;
    assign rem   = q.part[DSW-1:0];

    // R3/R5: every finished division leaves a remainder below its divisor
    a_r3_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ({1'b0, rem} < {1'b0, q.den}));
endmodule

// File: rtl/dpll_cand_eval.sv
module dpll_cand_eval
    import dpll_pkg::*;
(
    input  logic [FW-1:0] f_vco,
    input  logic [NW-1:0] n_val,
    input  logic [MW-1:0] m_val,
    input  logic [FW-1:0] best_err,
    output logic          take,
    output logic [FW-1:0] cand_err
);
    logic [MW-1:0] m_eff;
    logic [FW-1:0] n_w, m_w, prod_f, prod_r;

    always_comb begin
        // fine regime uses M as is; coarse regime drops the two low bits
        if (m_val >= M_FINE_LO && m_val <= M_FINE_HI) m_eff = m_val;
        else                                          m_eff = {m_val[MW-1:2], 2'b00};
        n_w      = FW'(n_val);
        m_w      = FW'(m_eff);
        prod_f   = f_vco * n_w;
        prod_r   = REF_HZ * m_w;
        cand_err = (prod_f >= prod_r) ? (prod_f - prod_r) : (prod_r - prod_f);
        take     = (m_val <= M_CRS_HI) && (cand_err < best_err);
    end
endmodule

// File: rtl/dpll_param_search.sv
module dpll_param_search
    import dpll_pkg::*;
#(
    parameter int PW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [PW-1:0] period_ps,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [7:0]    m_code,
    output logic [7:0]    n_code,
    output logic [7:0]    div_code
);
    localparam int DSW = (PW > 24) ? PW : 24;

    typedef struct packed {
        srch_state_e    st;
        logic [PW-1:0]  p;
        logic [FW-1:0]  ratio;
        logic [FW-1:0]  f;
        logic [7:0]     post;
        logic [MW-1:0]  rat2;
        logic [FW-1:0]  rem2;
        logic [NW-1:0]  n;
        logic [MW-1:0]  m;
        logic [FW-1:0]  res;
        logic [NW-1:0]  best_n;
        logic [MW-1:0]  best_m;
        logic [FW-1:0]  best_err;
        logic           div_go;
        logic [FW-1:0]  div_a;
        logic [DSW-1:0] div_b;
        logic           done;
        logic           err;
        logic [7:0]     m_code;
        logic [7:0]     n_code;
        logic [7:0]     div_code;
    } srch_t;

    srch_t q, d;

    logic           dv_valid;
    logic [FW-1:0]  dv_quot;
    logic [DSW-1:0] dv_rem;
    logic           take;
    logic [FW-1:0]  cand_err;
    logic [FW-1:0]  sum;

    dpll_divider #(.DVW(FW), .DSW(DSW)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (q.div_go),
        .dividend(q.div_a),
        .divisor (q.div_b),
        .valid   (dv_valid),
        .quot    (dv_quot),
        .rem     (dv_rem)
    );

    dpll_cand_eval u_eval (
        .f_vco   (q.f),
        .n_val   (q.n),
        .m_val   (q.m),
        .best_err(q.best_err),
        .take    (take),
        .cand_err(cand_err)
    );

    always_comb begin
        d        = q;
        d.div_go = 1'b0;
        d.done   = 1'b0;
        sum      = q.res + q.rem2;
        unique case (q.st)
            S_IDLE: if (start) begin
                d.err = 1'b0;
                if (period_ps == '0) begin
                    d.done = 1'b1;
                    d.err  = 1'b1;
                end else begin
                    d.p      = period_ps;
                    d.div_a  = ONE_M;
                    d.div_b  = DSW'(period_ps);
                    d.div_go = 1'b1;
                    d.st     = S_DIV_A;
                end
            end
            S_DIV_A: if (dv_valid) begin
                d.ratio  = dv_quot;
                d.div_a  = ONE_M * FW'(dv_rem);
                d.div_b  = DSW'(q.p);
                d.div_go = 1'b1;
                d.st     = S_DIV_B;
            end
            S_DIV_B: if (dv_valid) begin
                d.f  = ONE_M * q.ratio + dv_quot;
                d.st = S_RANGE;
            end
            S_RANGE: begin
                if (q.f < F_MIN || q.f > F_MAX) begin
                    d.done = 1'b1;
                    d.err  = 1'b1;
                    d.st   = S_IDLE;
                end else begin
                    d.post = '0;
                    d.st   = S_DOUBLE;
                end
            end
            S_DOUBLE: begin
                if (q.f < F_VCO_LO) begin
                    d.f    = {q.f[FW-2:0], 1'b0};
                    d.post = q.post + POST_STEP;
                end else begin
                    d.div_a  = q.f;
                    d.div_b  = DSW'(REF_HZ);
                    d.div_go = 1'b1;
                    d.st     = S_DIV_C;
                end
            end
            S_DIV_C: if (dv_valid) begin
                // state for N = 1: M and remainder of F / Fref
                d.rat2     = dv_quot[MW-1:0];
                d.rem2     = FW'(dv_rem);
                d.n        = 9'd1;
                d.m        = dv_quot[MW-1:0];
                d.res      = FW'(dv_rem);
                d.best_err = '1;
                d.best_n   = '0;
                d.best_m   = '0;
                d.st       = S_SWEEP;
            end
            S_SWEEP: begin
                if (q.n >= N_FIRST && take) begin
                    d.best_n   = q.n;
                    d.best_m   = q.m;
                    d.best_err = cand_err;
                end
                if (q.n == N_LAST) begin
                    d.st = S_FIN;
                end else begin
                    d.n = q.n + 1'b1;
                    if (sum >= REF_HZ) begin
                        d.res = sum - REF_HZ;
                        d.m   = q.m + q.rat2 + 1'b1;
                    end else begin
                        d.res = sum;
                        d.m   = q.m + q.rat2;
                    end
                end
            end
            S_FIN: begin
                d.n_code = 8'(q.best_n - 9'd2);
                if (q.best_m > M_FINE_HI) begin
                    d.m_code   = 8'((q.best_m >> 2) - 16'd2);
                    d.div_code = q.post;
                end else begin
                    d.m_code   = 8'(q.best_m - 16'd2);
                    d.div_code = q.post | LOOP_DIV1;
                end
                d.done = 1'b1;
                d.st   = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = (q.st != S_IDLE);
    assign done     = q.done;
    assign err      = q.err;
    assign m_code   = q.m_code;
    assign n_code   = q.n_code;
    assign div_code = q.div_code;

    a_r2_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r3_reject_keeps_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> ($stable(m_code) && $stable(n_code) && $stable(div_code)));
    a_r5_best_m_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_SWEEP && q.n >= N_FIRST && take) |=> (q.best_m <= M_CRS_HI));
    a_r6_best_err_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_SWEEP && $past(q.st == S_SWEEP)) |-> (q.best_err <= $past(q.best_err)));
    a_r7_unused_code_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (div_code[3] == 1'b0 && div_code[1:0] == 2'b00));
    a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(q.p));
endmodule

// File: tb/dpll_param_search_test.sv
module dpll_param_search_test;
    localparam int PW = 24;
    localparam int NV = 10;
    localparam int unsigned VEC [NV] = '{39722, 10000, 25000, 4546, 320000,
                                         100000, 50000, 15000, 7000, 200000};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [PW-1:0] period_ps = '0;
    logic          busy, done, err;
    logic [7:0]    m_code, n_code, div_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dpll_param_search #(.PW(PW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .period_ps(period_ps),
        .busy(busy), .done(done), .err(err),
        .m_code(m_code), .n_code(n_code), .div_code(div_code)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference model written from the requirements
    task automatic model(input longint unsigned p, output bit e, output byte unsigned mc,
                         output byte unsigned nc, output byte unsigned dc);
        longint unsigned f, ratio, rem, m, mq, er, be, bm, bn;
        byte unsigned post;
        e = 1'b0; mc = 0; nc = 0; dc = 0;
        if (p == 0) begin e = 1'b1; return; end
        ratio = 64'd1000000 / p;
        rem   = 64'd1000000 % p;
        f     = 64'd1000000 * ratio + (64'd1000000 * rem) / p;
        if (f < 64'd3125000 || f > 64'd220000000) begin e = 1'b1; return; end
        post = 0;
        while (f < 64'd100000000) begin f = f * 2; post = post + 8'h10; end
        be = '1; bm = 0; bn = 0;
        for (int n = 3; n <= 257; n++) begin
            m = (longint'(n) * f) / 64'd14318180;
            if (m > 1028) continue;
            mq = (m >= 3 && m <= 257) ? m : (m & ~64'd3);
            er = longint'(n) * f - 64'd14318180 * mq;
            if (er < be) begin be = er; bm = m; bn = n; end
        end
        nc = 8'(bn - 2);
        if (bm > 257) begin mc = 8'((bm >> 2) - 2); dc = post; end
        else          begin mc = 8'(bm - 2);        dc = post | 8'h04; end
    endtask

    task automatic pulse_start(input logic [PW-1:0] p);
        @(negedge clk);
        period_ps = p;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int waited);
        waited = 0;
        while (!done && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic run_one(input logic [PW-1:0] p);
        bit e; byte unsigned mc, nc, dc; int w;
        byte unsigned om, on, od;
        om = m_code; on = n_code; od = div_code;
        model(longint'(p), e, mc, nc, dc);
        pulse_start(p);
        if (!done) wait_done(w);
        check(done == 1'b1, "R2 done reached", done, 1);
        check(busy == 1'b0, "R2 busy low at done", busy, 0);
        check(err == e, "R3 err flag", err, e);
        if (e) begin
            check(m_code == om && n_code == on && div_code == od, "R3 codes kept",
                  {m_code, n_code, div_code}, {om, on, od});
        end else begin
            check(div_code[7:4] == dc[7:4], "R4 doubling count", div_code[7:4], dc[7:4]);
            check(n_code == nc, "R5/R6 n_code", n_code, nc);
            check(m_code == mc, "R5/R6 m_code", m_code, mc);
            check(div_code == dc, "R7 div_code", div_code, dc);
        end
        @(negedge clk);
        check(done == 1'b0, "R2 done single cycle", done, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bit e; byte unsigned mc, nc, dc; int w, dones;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 0, "R1 busy", busy, 0);
        check(done == 0, "R1 done", done, 0);
        check(err == 0, "R1 err", err, 0);
        check({m_code, n_code, div_code} == 24'd0, "R1 codes", {m_code, n_code, div_code}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: busy rises on the edge after start
        @(negedge clk);
        period_ps = 24'd39722;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        wait_done(w);
        @(negedge clk);

        // main table
        for (int i = 0; i < NV; i++) run_one(VEC[i][PW-1:0]);

        // R3 window edges and degenerate periods
        run_one(24'd4545);
        run_one(24'd320001);
        run_one(24'd0);
        run_one(24'd2000000);
        run_one(24'd320000);

        // R8: start while busy is ignored
        model(64'd25000, e, mc, nc, dc);
        pulse_start(24'd25000);
        repeat (20) @(negedge clk);
        period_ps = 24'd10000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        period_ps = 24'd25000;
        dones = 0;
        for (int c = 0; c < 1200; c++) begin
            if (done) begin
                dones++;
                check(m_code == mc && n_code == nc && div_code == dc, "R8 first request result",
                      {m_code, n_code, div_code}, {mc, nc, dc});
            end
            @(negedge clk);
        end
        check(dones == 1, "R8 single done", dones, 1);
        check(busy == 0, "R8 idle afterwards", busy, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule